// File: doc/BRIEF.md
# DIP-4 Link Synchronization Tracker

This block follows the synchronization state of a packet-interface receive link from a stream of per-word parity-check outcomes. Each outcome arrives as a one-cycle strobe carrying a pass or fail flag. While the link is out of lock, the block counts passing checks in an unbroken run and declares lock once that run reaches a programmable threshold. While in lock, it counts failing checks in an unbroken run and drops lock once that run reaches a second programmable threshold. Whenever lock is absent, the block raises a request that tells the status-channel encoder to send the framing pattern.

A single 32-bit control and status word holds both thresholds and a running total of failed checks. Reading the word clears the total. A periodic-training input lowers the effective loss threshold by one. Software compensates for this by programming the loss field one higher than the number of failures it wants.

Top module: `dip4_sync_tracker`

## Requirements
- R1: After a synchronous active-high reset, the status word reads 0x00000420, `in_sync` is 0 and `framing_req` is 1.
- R2: Bits 7:0 of the status word hold the lock threshold, bits 15:8 the loss threshold and bits 31:16 the failure total. A write loads bits 15:0 into the two thresholds and has no effect on the failure total.
- R3: While out of lock, the block declares lock when the number of consecutive passing checks reaches the lock threshold. A failing check restarts that run, and cycles without a check strobe leave it unchanged.
- R4: While in lock with training off, the block drops lock when the number of consecutive failing checks reaches the loss threshold. A passing check restarts that run.
- R5: While `train_en` is 1, lock is dropped at one failing check fewer than the loss threshold.
- R6: `in_sync` and `framing_req` are registered and always complementary. Each changes only in the cycle after the check strobe that causes a transition.
- R7: The failure total counts every failing check, whether the link is in lock or not. A read returns the current total in the same cycle and clears it to zero.
- R8: When a read and a failing check fall in the same cycle, the read returns the old total and the total becomes 1.
- R9: The failure total saturates at 0xFFFF and does not wrap.
- R10: A threshold write changes neither `in_sync` nor `framing_req`. The new value governs the next check that follows the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Strobe marking one parity-check outcome |
| chk_pass | input | 1 | 1 = check passed, 0 = failed; sampled with chk_valid |
| train_en | input | 1 | Periodic training active; lowers the loss threshold by one |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data; bits 15:0 are used |
| reg_rd | input | 1 | Read strobe; clears the failure total |
| reg_rdata | output | 32 | Current status word |
| in_sync | output | 1 | Link is in lock |
| framing_req | output | 1 | Request to send the framing pattern on the status channel |

## Verification
The bench builds the block with its default parameters: 8-bit thresholds resetting to 32 and 4, and a 16-bit total. The reset thresholds are therefore exercised exactly at their boundaries, 31 versus 32 passes and 3 versus 4 failures. Because the total is 16 bits wide, its saturation at 0xFFFF can be reached within the run by a continuous stream of failures. Smaller thresholds written through the register make the vector table short, and this brings within reach restart-on-break, idle cycles, the training reduction and mid-run threshold writes.

// File: rtl/dip4_pkg.sv
package dip4_pkg;

  typedef enum logic {
    LNK_HUNT   = 1'b0,
    LNK_LOCKED = 1'b1
  } link_state_e;

  // Loss threshold after the training reduction; never goes below zero.
  function automatic logic [7:0] loss_limit(input logic [7:0] thr, input logic train);
    loss_limit = (train && thr != 8'd0) ? thr - 8'd1 : thr;
  endfunction

endpackage

// File: rtl/dip4_cfg_reg.sv
module dip4_cfg_reg #(
  parameter int THR_W      = 8,
  parameter int LOCK_RST   = 32,
  parameter int UNLOCK_RST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [THR_W-1:0] wr_lock,
  input  logic [THR_W-1:0] wr_unlock,
  output logic [THR_W-1:0] lock_thr,
  output logic [THR_W-1:0] unlock_thr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_thr   <= THR_W'(LOCK_RST);
      unlock_thr <= THR_W'(UNLOCK_RST);
    end else if (wr_en) begin
      lock_thr   <= wr_lock;
      unlock_thr <= wr_unlock;
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (lock_thr == $past(wr_lock) && unlock_thr == $past(wr_unlock)));

  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(lock_thr) && $stable(unlock_thr));

endmodule

// File: rtl/dip4_err_tally.sv
module dip4_err_tally #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_evt,
  input  logic             rd_clr,
  output logic [ERR_W-1:0] total
);

  localparam logic [ERR_W-1:0] SAT = {ERR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      total <= '0;
    end else if (rd_clr) begin
      total <= err_evt ? ERR_W'(1) : '0;
    end else if (err_evt && total != SAT) begin
      total <= total + ERR_W'(1);
    end
  end

  assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
    (total == SAT && !rd_clr) |=> total == SAT);

  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !err_evt) |=> total == '0);

  assert_read_and_error_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && err_evt) |=> total == ERR_W'(1));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (err_evt && !rd_clr && total != SAT) |=> total == $past(total) + ERR_W'(1));

endmodule

// File: rtl/dip4_sync_fsm.sv
module dip4_sync_fsm
  import dip4_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_valid,
  input  logic             chk_pass,
  input  logic             train_en,
  input  logic [THR_W-1:0] lock_thr,
  input  logic [THR_W-1:0] unlock_thr,
  output logic             in_sync,
  output logic             framing_req
);

  localparam int CW = THR_W + 1;

  link_state_e      state_q, state_d;
  logic [THR_W-1:0] run_q, run_d;
  logic [CW-1:0]    run_inc;
  logic [THR_W-1:0] loss_thr;

  assign run_inc  = {1'b0, run_q} + CW'(1);
  assign loss_thr = THR_W'(loss_limit(8'(unlock_thr), train_en));

  // One run counter serves both states: passes while hunting, failures while locked.
  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (chk_valid) begin
      unique case (state_q)
        LNK_HUNT: begin
          if (!chk_pass) begin
            run_d = '0;
          end else if (run_inc >= {1'b0, lock_thr}) begin
            state_d = LNK_LOCKED;
            run_d   = '0;
          end else begin
            run_d = run_inc[THR_W-1:0];
          end
        end
        LNK_LOCKED: begin
          if (chk_pass) begin
            run_d = '0;
          end else if (run_inc >= {1'b0, loss_thr}) begin
            state_d = LNK_HUNT;
            run_d   = '0;
          end else begin
            run_d = run_inc[THR_W-1:0];
          end
        end
        default: state_d = LNK_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= LNK_HUNT;
      run_q       <= '0;
      in_sync     <= 1'b0;
      framing_req <= 1'b1;
    end else begin
      state_q     <= state_d;
      run_q       <= run_d;
      in_sync     <= (state_d == LNK_LOCKED);
      framing_req <= (state_d == LNK_HUNT);
    end
  end

  assert_outputs_complement_R6: assert property (@(posedge clk) disable iff (rst)
    framing_req == !in_sync);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> $stable(in_sync));

  assert_fail_blocks_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_sync && chk_valid && !chk_pass) |=> !in_sync);

  assert_pass_keeps_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (in_sync && chk_valid && chk_pass) |=> in_sync);

endmodule

// File: rtl/dip4_sync_tracker.sv
module dip4_sync_tracker #(
  parameter int ERR_W      = 16,
  parameter int THR_W      = 8,
  parameter int LOCK_RST   = 32,
  parameter int UNLOCK_RST = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       chk_valid,
  input  logic                       chk_pass,
  input  logic                       train_en,
  input  logic                       reg_wr,
  input  logic [ERR_W+2*THR_W-1:0]   reg_wdata,
  input  logic                       reg_rd,
  output logic [ERR_W+2*THR_W-1:0]   reg_rdata,
  output logic                       in_sync,
  output logic                       framing_req
);

  localparam int LOCK_LSB   = 0;
  localparam int UNLOCK_LSB = THR_W;
  localparam int ERR_LSB    = 2 * THR_W;

  logic [THR_W-1:0] lock_thr, unlock_thr;
  logic [ERR_W-1:0] err_total;

  dip4_cfg_reg #(
    .THR_W(THR_W), .LOCK_RST(LOCK_RST), .UNLOCK_RST(UNLOCK_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr),
    .wr_lock(reg_wdata[LOCK_LSB +: THR_W]),
    .wr_unlock(reg_wdata[UNLOCK_LSB +: THR_W]),
    .lock_thr(lock_thr), .unlock_thr(unlock_thr)
  );

  dip4_sync_fsm #(.THR_W(THR_W)) u_fsm (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_pass(chk_pass),
    .train_en(train_en), .lock_thr(lock_thr), .unlock_thr(unlock_thr),
    .in_sync(in_sync), .framing_req(framing_req)
  );

  dip4_err_tally #(.ERR_W(ERR_W)) u_tally (
    .clk(clk), .rst(rst), .err_evt(chk_valid && !chk_pass),
    .rd_clr(reg_rd), .total(err_total)
  );

  assign reg_rdata = {err_total, unlock_thr, lock_thr};

  assert_err_field_not_written_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_rd && !chk_valid) |=> $stable(reg_rdata[ERR_LSB +: ERR_W]));

endmodule

// File: tb/test_dip4_sync_tracker.sv
module test_dip4_sync_tracker;

  logic        clk = 1'b0;
  logic        rst;
  logic        chk_valid, chk_pass, train_en;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        in_sync, framing_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dip4_sync_tracker i_dip4_sync_tracker (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_pass(chk_pass),
    .train_en(train_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .in_sync(in_sync),
    .framing_req(framing_req)
  );

  // {valid, pass, train, expected in_sync}; thresholds lock=3, loss=3
  localparam logic [3:0] VEC [18] = '{
    4'b1100, 4'b1100, 4'b1000, 4'b1100, 4'b0000, 4'b1100, 4'b1101,
    4'b1001, 4'b1001, 4'b1101, 4'b1001, 4'b1010,
    4'b1100, 4'b1100, 4'b1101, 4'b1001, 4'b1001, 4'b1000
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_sync(input string req, input logic exp);
    checks++;
    if (in_sync !== exp || framing_req !== !exp) begin
      errors++;
      $display("FAIL %s: actual in_sync=%b framing_req=%b expected in_sync=%b framing_req=%b",
               req, in_sync, framing_req, exp, !exp);
    end
  endtask

  task automatic do_read(output logic [31:0] val);
    reg_rd = 1'b1;
    #1 val = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] val);
    reg_wr = 1'b1;
    reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_checks(input int n, input logic pass);
    chk_valid = 1'b1;
    chk_pass  = pass;
    repeat (n) @(negedge clk);
    chk_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rv;
    rst = 1'b1; chk_valid = 0; chk_pass = 0; train_en = 0;
    reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check32("R1 reset word", reg_rdata, 32'h0000_0420);
    check_sync("R1 reset flags", 1'b0);

    // R3 default lock threshold 32
    run_checks(31, 1'b1);
    check_sync("R3 31 passes stay unlocked", 1'b0);
    run_checks(1, 1'b1);
    check_sync("R3 32nd pass locks", 1'b1);
    // R4 default loss threshold 4
    run_checks(3, 1'b0);
    check_sync("R4 3 fails keep lock", 1'b1);
    run_checks(1, 1'b0);
    check_sync("R4 4th fail drops lock", 1'b0);

    // R7 total and clear on read
    do_read(rv);
    check32("R7 total of 4", rv, 32'h0004_0420);
    do_read(rv);
    check32("R7 cleared after read", rv, 32'h0000_0420);

    // R2 error field not writable
    do_write(32'hABCD_0303);
    check32("R2 write thresholds only", reg_rdata, 32'h0000_0303);

    // R3 R4 R5 R6 vector table
    foreach (VEC[i]) begin
      chk_valid = VEC[i][3];
      chk_pass  = VEC[i][2];
      train_en  = VEC[i][1];
      @(negedge clk);
      check_sync($sformatf("R6 vector %0d", i), VEC[i][0]);
    end
    chk_valid = 0; train_en = 0;

    do_read(rv);
    check32("R7 total after table", rv, 32'h0008_0303);
    do_read(rv);
    check32("R7 cleared again", rv, 32'h0000_0303);

    // R10 threshold write leaves state, applies next check
    do_write(32'h0000_0101);
    check_sync("R10 write keeps unlocked", 1'b0);
    run_checks(1, 1'b1);
    check_sync("R10 new lock threshold 1", 1'b1);
    do_write(32'h0000_0501);
    check_sync("R10 write keeps locked", 1'b1);

    // R8 read and failure in same cycle
    run_checks(2, 1'b0);
    chk_valid = 1'b1; chk_pass = 1'b0;
    do_read(rv);
    chk_valid = 1'b0;
    check32("R8 read returns old total", rv, 32'h0002_0501);
    do_read(rv);
    check32("R8 total restarted at 1", rv, 32'h0001_0501);
    check_sync("R4 3 fails under loss 5 keep lock", 1'b1);

    // R9 saturation
    run_checks(65540, 1'b0);
    check_sync("R4 long failure run drops lock", 1'b0);
    do_read(rv);
    check32("R9 saturated total", rv, 32'hFFFF_0501);

    // R1 reset again mid-run
    run_checks(1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check32("R1 reset word again", reg_rdata, 32'h0000_0420);
    check_sync("R1 reset flags again", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule